// File: doc/BRIEF.md
# Multi-Format Serial Audio Deserializer

This block receives stereo PCM audio on a three-wire serial link: a bit clock, a frame clock that selects the channel, and a data line. It turns each channel slot into one parallel sample. The block runs on a system clock that oversamples the bit clock. All three serial wires pass through synchronizers. A rising edge of the synchronized bit clock marks the sampling point for both the data bit and the frame-clock level.

Three framing conventions are supported. They differ in which frame-clock level means "left" and in how far the most significant bit sits from the frame-clock change. In the right-justified convention the first data bit is placed so that the last data bit falls on the final bit clock of a 32-bit slot. Sample widths of 16, 18, 20 and 24 bits work in every convention. Every sample is sign-extended to 24 bits. The framing and width settings are static inputs, and the block adopts a new setting only when a new left slot begins.

Finished samples leave through a valid/ready port that holds one entry. The serial link cannot be stalled, so back-pressure never stops reception. A sample waits in the output register with `out_valid` high until `out_ready` is seen high. If a newer sample completes before that happens, the newer sample replaces the waiting one. When a replacement and an acceptance fall in the same cycle, the replacement wins and `out_valid` stays high.

Top module: `serial_audio_deser`

## Requirements
- R1: After reset `out_valid` is low. No sample is produced until the sampled frame clock changes level for the first time. That first change adopts the current `cfg_fmt`/`cfg_wsel` setting whatever slot it opens.
- R2: With `cfg_fmt`=1 (left-justified), a high frame clock is the left slot. The MSB is the data bit sampled on the first bit-clock rising edge that sees the new frame-clock level.
- R3: With `cfg_fmt`=0 (I2S, and also code 3), a low frame clock is the left slot. The MSB is sampled one bit-clock rising edge later than in R2.
- R4: With `cfg_fmt`=2 (right-justified), a high frame clock is the left slot. The MSB is sampled on rising edge number 32−W, counting from 0 at the first edge of the slot. The LSB is therefore taken on edge 31.
- R5: `cfg_wsel` 0/1/2/3 selects W = 16/18/20/24. Bits arrive MSB first. `out_sample` carries the W bits sign-extended to 24 bits.
- R6: Data bits outside the W-bit capture window of a slot have no effect on the output.
- R7: A change in the sampled frame clock restarts the bit count. A slot that ends before its last capture index produces no sample, and the slot that follows decodes correctly. Samples are produced only from bit-clock rising edges.
- R8: A new `cfg_fmt`/`cfg_wsel` setting takes effect at the next frame-clock change that opens a left slot under the setting already in use. The new setting governs that slot from its first bit onward.
- R9: `out_right` is 1 for a right-slot sample and 0 for a left-slot sample. With `out_ready` held high, each sample appears with `out_valid` high for exactly one cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_sample` and `out_right` stay unchanged unless a newer sample arrives.
- R11: A sample that completes while another is waiting replaces it, and `out_valid` stays high. After `out_ready` is seen high with no new arrival, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_lrclk | input | 1 | Serial frame/channel clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as I2S |
| cfg_wsel | input | 2 | Width: 0=16, 1=18, 2=20, 3=24 bits |
| out_ready | input | 1 | Consumer accepts the waiting sample |
| out_valid | output | 1 | A sample is waiting |
| out_sample | output | 24 | Sign-extended sample |
| out_right | output | 1 | Channel tag, 1 = right slot |

## Verification
Two events can land in the same system-clock cycle: the frame-clock change that adopts a pending setting, and the capture of that slot's first data bit in left-justified framing. The bench provokes this by changing the setting from right-justified 24-bit to left-justified 20-bit partway through a left slot. The next frame is then sent in the new format. That frame's left MSB is taken on the very edge that adopts the setting, so a design that applies the setting one edge late shows a shifted, wrongly extended value. The bench judges this by comparing all six samples of the three frames with values it computes itself. The frames before the switch must keep the old format and the frame after it must use the new one.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
package sad_pkg;

  localparam int SAMPLE_W = 24;
  localparam int NUM_WSEL = 4;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_ALT   = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] wsel;
  } cfg_t;

  // Word width selected by a width code.
  function automatic int unsigned width_of(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // Frame-clock level that marks the left slot.
  function automatic logic left_level(input fmt_e fmt);
    return (fmt == FMT_LEFT) || (fmt == FMT_RIGHT);
  endfunction

  // Index (from 0 at the first edge of a slot) of the MSB.
  function automatic int unsigned start_of(input fmt_e fmt, input logic [1:0] wsel,
                                           input int unsigned slot_bits);
    case (fmt)
      FMT_LEFT:  return 0;
      FMT_RIGHT: return slot_bits - width_of(wsel);
      default:   return 1;
    endcase
  endfunction

endpackage

// File: rtl/sad_front.sv
`timescale 1ns/1ps
module sad_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrclk_in,
  input  logic data_in,
  output logic bit_stb,
  output logic lr_s,
  output logic sd_s
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] chain [STAGES];
  logic            bclk_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= {bclk_in, lrclk_in, data_in};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= chain[STAGES-1][2];
  end

  assign bit_stb = chain[STAGES-1][2] & ~bclk_d;
  assign lr_s    = chain[STAGES-1][1];
  assign sd_s    = chain[STAGES-1][0];
endmodule

// File: rtl/sad_slot_ctl.sv
`timescale 1ns/1ps
module sad_slot_ctl
  import sad_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       lr_s,
  input  cfg_t       cfg_in,
  output logic       cap_en,
  output logic       last_bit,
  output logic       is_right,
  output logic [1:0] cur_wsel,
  output cfg_t       act_cfg
);
  localparam int CW = $clog2(SLOT_BITS) + 1;
  localparam logic [CW-1:0] IDX_SAT = '1;
  localparam cfg_t CFG_RST = '{fmt: FMT_I2S, wsel: 2'd0};

  logic          lr_prev_q, primed_q;
  logic [CW-1:0] idx_q, idx_now, start_idx, last_idx;
  cfg_t          act_q, pend_q, cfg_now;
  logic          lr_edge, enter_left, do_load;

  always_comb begin
    lr_edge    = bit_stb && (lr_s != lr_prev_q);
    enter_left = lr_edge && (lr_s == left_level(act_q.fmt));
    do_load    = lr_edge && (!primed_q || enter_left);
    cfg_now    = do_load ? pend_q : act_q;
    if (lr_edge)              idx_now = '0;
    else if (idx_q == IDX_SAT) idx_now = IDX_SAT;
    else                      idx_now = idx_q + CW'(1);
    start_idx = CW'(start_of(cfg_now.fmt, cfg_now.wsel, SLOT_BITS));
    last_idx  = start_idx + CW'(width_of(cfg_now.wsel)) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      idx_q     <= IDX_SAT;
      act_q     <= CFG_RST;
      pend_q    <= CFG_RST;
    end else begin
      pend_q <= cfg_in;
      if (bit_stb) begin
        lr_prev_q <= lr_s;
        idx_q     <= idx_now;
      end
      if (do_load) begin
        act_q    <= pend_q;
        primed_q <= 1'b1;
      end
    end
  end

  assign cap_en   = bit_stb && (idx_now >= start_idx) && (idx_now <= last_idx);
  assign last_bit = bit_stb && (idx_now == last_idx);
  assign is_right = (lr_s != left_level(cfg_now.fmt));
  assign cur_wsel = cfg_now.wsel;
  assign act_cfg  = act_q;
endmodule

// File: rtl/sad_shift.sv
`timescale 1ns/1ps
module sad_shift
  import sad_pkg::*;
#(
  parameter int OUT_W = SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             last_bit,
  input  logic             sd_s,
  input  logic             is_right,
  input  logic [1:0]       wsel,
  output logic             word_vld,
  output logic [OUT_W-1:0] word,
  output logic             word_right
);
  logic [OUT_W-2:0] sh_q;
  logic [OUT_W-1:0] assembled;
  logic [OUT_W-1:0] ext [NUM_WSEL];

  assign assembled = {sh_q, sd_s};

  for (genvar g = 0; g < NUM_WSEL; g++) begin : g_ext
    localparam int WB = int'(width_of(2'(g)));
    if (WB >= OUT_W) begin : g_full
      assign ext[g] = assembled;
    end else begin : g_sign
      assign ext[g] = {{(OUT_W-WB){assembled[WB-1]}}, assembled[WB-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      word_vld   <= 1'b0;
      word       <= '0;
      word_right <= 1'b0;
    end else begin
      if (cap_en) sh_q <= assembled[OUT_W-2:0];
      word_vld <= last_bit;
      if (last_bit) begin
        word       <= ext[wsel];
        word_right <= is_right;
      end
    end
  end
endmodule

// File: rtl/sad_out_reg.sv
`timescale 1ns/1ps
module sad_out_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_word,
  input  logic         in_right,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_sample,
  output logic         out_right
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_right  <= 1'b0;
    end else if (in_vld) begin
      out_valid  <= 1'b1;
      out_sample <= in_word;
      out_right  <= in_right;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_audio_deser.sv
`timescale 1ns/1ps
module serial_audio_deser
  import sad_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_bclk,
  input  logic                ser_lrclk,
  input  logic                ser_data,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wsel,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_right
);
  logic                bit_stb, lr_s, sd_s;
  logic                cap_en, last_bit, is_right;
  logic [1:0]          cur_wsel;
  cfg_t                cfg_in, act_cfg;
  logic                word_vld, word_right;
  logic [SAMPLE_W-1:0] word;

  assign cfg_in = '{fmt: fmt_e'(cfg_fmt), wsel: cfg_wsel};

  sad_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .bclk_in(ser_bclk), .lrclk_in(ser_lrclk), .data_in(ser_data),
    .bit_stb(bit_stb), .lr_s(lr_s), .sd_s(sd_s)
  );

  sad_slot_ctl #(.SLOT_BITS(SLOT_BITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .lr_s(lr_s), .cfg_in(cfg_in),
    .cap_en(cap_en), .last_bit(last_bit), .is_right(is_right),
    .cur_wsel(cur_wsel), .act_cfg(act_cfg)
  );

  sad_shift #(.OUT_W(SAMPLE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .last_bit(last_bit),
    .sd_s(sd_s), .is_right(is_right), .wsel(cur_wsel),
    .word_vld(word_vld), .word(word), .word_right(word_right)
  );

  sad_out_reg #(.W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_vld(word_vld), .in_word(word),
    .in_right(word_right), .out_ready(out_ready),
    .out_valid(out_valid), .out_sample(out_sample), .out_right(out_right)
  );
endmodule

// File: rtl/sad_checker.sv
`timescale 1ns/1ps
module sad_checker
  import sad_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_sample,
  input logic                out_right,
  input logic                word_vld,
  input logic                word_right,
  input logic                bit_stb,
  input cfg_t                act_cfg
);
  assert_one_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !word_vld |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !word_vld |=> out_valid && $stable(out_sample) && $stable(out_right));

  assert_replace_R11: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> out_valid && (out_right == $past(word_right)));

  assert_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(bit_stb));

  assert_cfg_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg) |-> $past(bit_stb));
endmodule

bind serial_audio_deser sad_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_sample(out_sample), .out_right(out_right), .word_vld(word_vld),
  .word_right(word_right), .bit_stb(bit_stb), .act_cfg(act_cfg)
);

// File: tb/tb_serial_audio_deser.sv
`timescale 1ns/1ps
module tb_serial_audio_deser;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, bclk, lrc, sdat, rdy;
  logic [1:0]  cfg_fmt, cfg_wsel;
  logic        out_valid, out_right;
  logic [23:0] out_sample;

  int checks = 0, fails = 0;
  logic [23:0] got_v [64];
  logic        got_r [64];
  int          n_got = 0;
  logic [1:0]  nxt_fmt = 2'd0, nxt_wsel = 2'd0;

  serial_audio_deser dut (
    .clk(clk), .rst_n(rst_n), .ser_bclk(bclk), .ser_lrclk(lrc), .ser_data(sdat),
    .cfg_fmt(cfg_fmt), .cfg_wsel(cfg_wsel), .out_ready(rdy),
    .out_valid(out_valid), .out_sample(out_sample), .out_right(out_right)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && rdy) begin
      if (n_got < 64) begin
        got_v[n_got] = out_sample;
        got_r[n_got] = out_right;
      end
      n_got++;
    end
  end

  function automatic int wbits(input int ws);
    case (ws) 0: return 16; 1: return 18; 2: return 20; default: return 24; endcase
  endfunction

  function automatic int first_idx(input int fmt, input int w);
    if (fmt == 1) return 0;
    if (fmt == 2) return 32 - w;
    return 1;
  endfunction

  function automatic logic lr_of(input int fmt, input int ch);
    if (fmt == 1 || fmt == 2) return (ch == 0);
    return (ch != 0);
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] v, input int w);
    logic [23:0] r;
    for (int b = 0; b < 24; b++) r[b] = (b < w) ? v[b] : v[w-1];
    return r;
  endfunction

  function automatic logic [23:0] mkval(input int i, input int ch, input int w);
    logic [31:0] x;
    x = i * 32'h0002F1B3 + ch * 32'h0005A5A5 + 32'h00C00813;
    return x[23:0] & ((24'h1 << w) - 24'h1);
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic lr, input logic d);
    @(posedge clk); #1;
    bclk = 1'b0; lrc = lr; sdat = d;
    repeat (4) @(posedge clk);
    #1 bclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_slot(input int fmt, input int ws, input int ch,
                           input logic [23:0] val, input int len, input int chg_at);
    int w, st;
    logic lr;
    w  = wbits(ws);
    st = first_idx(fmt, w);
    lr = lr_of(fmt, ch);
    for (int k = 0; k < len; k++) begin
      logic b;
      if (k >= st && k < st + w) b = val[w-1-(k-st)];
      else                      b = (((k * 5 + ch) % 3) == 0);
      if (k == chg_at) begin
        cfg_fmt  = nxt_fmt;
        cfg_wsel = nxt_wsel;
      end
      drive_bit(lr, b);
    end
  endtask

  task automatic do_reset(input int fmt, input int ws);
    @(posedge clk); #1;
    rst_n = 1'b0; bclk = 1'b0; sdat = 1'b0;
    cfg_fmt = 2'(fmt); cfg_wsel = 2'(ws);
    lrc = lr_of(fmt, 1);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int k = 0; k < 3; k++) drive_bit(lr_of(fmt, 1), 1'b1);
    n_got = 0;
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; lrc = 1'b0; sdat = 1'b0; rdy = 1'b1;
    cfg_fmt = 2'd1; cfg_wsel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 24'(out_valid), 24'h0);

    // R1: idle with no frame-clock change yields nothing
    do_reset(1, 0);
    settle();
    chk("R1 out_valid after reset", 24'(out_valid), 24'h0);
    chk("R1 no sample before first edge", 24'(n_got), 24'h0);

    // Sweep of all framings and widths (R2 R3 R4 R5 R6 R9)
    for (int f = 0; f < 3; f++) begin
      for (int ws = 0; ws < 4; ws++) begin
        logic [23:0] ev [4];
        string tag;
        int w;
        w = wbits(ws);
        tag = (f == 0) ? "R3" : (f == 1) ? "R2" : "R4";
        do_reset(f, ws);
        for (int fr = 0; fr < 2; fr++) begin
          ev[2*fr]   = mkval(f * 8 + ws * 2 + fr, 0, w);
          ev[2*fr+1] = mkval(f * 8 + ws * 2 + fr, 1, w);
          send_slot(f, ws, 0, ev[2*fr], 32, -1);
          send_slot(f, ws, 1, ev[2*fr+1], 32, -1);
        end
        settle();
        chk({tag, " R9 sample count"}, 24'(n_got), 24'd4);
        for (int i = 0; i < 4; i++) begin
          chk({tag, " R5 R6 sample value"}, got_v[i], sext(ev[i], w));
          chk({tag, " R9 channel tag"}, 24'(got_r[i]), 24'(i % 2));
        end
      end
    end

    // R7: a short left slot emits nothing; following slots decode
    begin
      logic [23:0] a, b;
      a = mkval(40, 1, 16);
      b = mkval(41, 0, 16);
      do_reset(1, 0);
      send_slot(1, 0, 0, 24'h00FFFF, 10, -1);
      send_slot(1, 0, 1, a, 32, -1);
      send_slot(1, 0, 0, b, 32, -1);
      settle();
      chk("R7 count after short slot", 24'(n_got), 24'd2);
      chk("R7 right after short slot", got_v[0], sext(a, 16));
      chk("R7 right tag", 24'(got_r[0]), 24'd1);
      chk("R7 next left", got_v[1], sext(b, 16));
    end

    // R8: switch RJ24 -> LJ20 mid left slot; adopted at next left slot
    begin
      logic [23:0] v [6];
      for (int i = 0; i < 4; i++) v[i] = mkval(50 + i, i % 2, 24);
      v[4] = mkval(60, 0, 20);
      v[5] = mkval(61, 1, 20);
      do_reset(2, 3);
      nxt_fmt = 2'd1; nxt_wsel = 2'd2;
      send_slot(2, 3, 0, v[0], 32, -1);
      send_slot(2, 3, 1, v[1], 32, -1);
      send_slot(2, 3, 0, v[2], 32, 4);
      send_slot(2, 3, 1, v[3], 32, -1);
      send_slot(1, 2, 0, v[4], 32, -1);
      send_slot(1, 2, 1, v[5], 32, -1);
      settle();
      chk("R8 count across switch", 24'(n_got), 24'd6);
      for (int i = 0; i < 4; i++) chk("R8 old format kept", got_v[i], sext(v[i], 24));
      chk("R8 new format left at boundary", got_v[4], sext(v[4], 20));
      chk("R8 new format right", got_v[5], sext(v[5], 20));
    end

    // R10 R11: back-pressure hold and replacement
    begin
      logic [23:0] l, r, held;
      l = mkval(70, 0, 16);
      r = mkval(71, 1, 16);
      do_reset(1, 0);
      @(posedge clk); #1 rdy = 1'b0;
      send_slot(1, 0, 0, l, 32, -1);
      send_slot(1, 0, 1, r, 32, -1);
      settle();
      chk("R10 nothing accepted", 24'(n_got), 24'd0);
      chk("R11 valid held", 24'(out_valid), 24'd1);
      chk("R11 newest tag", 24'(out_right), 24'd1);
      chk("R11 newest replaces", out_sample, sext(r, 16));
      held = out_sample;
      repeat (20) @(negedge clk);
      chk("R10 stable while stalled", out_sample, held);
      @(posedge clk); #1 rdy = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 accepted once", 24'(n_got), 24'd1);
      chk("R11 valid drops", 24'(out_valid), 24'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule